// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block drives and samples a bank of general-purpose pins through a flat register port. The port takes one access per cycle: an address, a write strobe and write data, with read data returned combinationally for the address presented. For each pin, software sets an output value and a drive enable. It also sets a pull resistor enable with an up/down choice and a 3-bit drive-strength code. The current pad level is read back through a two-stage synchronizer.

Every pin also has an event detector. Three configuration bits pick one of five trigger modes: rising edge, falling edge, both edges, high level or low level. Edge events latch into a raw status bit that stays set until software clears it by writing 1. Level events track the pad level. A per-pin enable mask gives a masked status view. One registered interrupt line is the OR of all masked status bits.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset, every writable register is 0. All pins are undriven, pulls are off, drive codes are 0, interrupts are masked and `irq` is low.
- R2: `pad_oe` equals the output-enable register (offset 0x08). `pad_out` carries the output-data register (0x04) only on pins whose enable bit is 1, and is 0 elsewhere.
- R3: Reading 0x00 returns the pad level seen two clock edges earlier, through a two-flop synchronizer.
- R4: In edge mode (bit n of 0x0C is 0) with dual-edge off (bit n of 0x10 is 0), polarity bit n of 0x14 chooses the edge. A value of 1 means rising and 0 means falling. The event sets raw status bit n (0x1C), which stays set until cleared. Edges of the other direction have no effect.
- R5: In edge mode with bit n of 0x10 set, both rising and falling edges set the status bit, whatever the polarity bit holds.
- R6: In level mode (bit n of 0x0C is 1), the status bit equals the active level each cycle: high when the polarity bit is 1, low when it is 0. A clear write cannot hold it at 0 while the level remains.
- R7: Reading 0x20 returns raw status AND the mask at 0x18, where 1 enables a pin. `irq` is the OR of those bits, registered one cycle later.
- R8: Writing 1 to bit n of 0x24 clears an edge-latched status bit, and writing 0 leaves it unchanged. If the clear lands in the same cycle as a new edge, the bit stays set.
- R9: A pull is active only when bit n of 0x38 is 1. Bit n of 0x34 then picks the direction: 1 asserts `pull_up[n]` and 0 asserts `pull_dn[n]`.
- R10: The drive code of pin n has bit i at bit n of the word at 0x58 + 4*i (i = 0..2). `drive_code[3n+2:3n]` outputs that code, where code = mA/2 - 1.
- R11: Writable registers read back at their offsets. Writes to 0x00 and 0x1C have no effect, 0x24 reads 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte offset of the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data, one bit per pin |
| rd_data | output | 32 | Read data for `addr` |
| pad_in | input | 32 | Pad levels (asynchronous) |
| pad_out | output | 32 | Output level per pin, gated by enable |
| pad_oe | output | 32 | Output enable per pin |
| pull_up | output | 32 | Pull-up active per pin |
| pull_dn | output | 32 | Pull-down active per pin |
| drive_code | output | 96 | 3-bit drive-strength code per pin |
| irq | output | 1 | Aggregated masked interrupt |

## Verification
Pins in different trigger modes receive isolated rising and falling transitions. This shows whether each mode responds only to its own edge direction, to both edges, or to a sustained level. A clear write is timed to the exact cycle a new edge is latched, which separates the correct "event wins" priority from a clear-wins design. Level-mode pins are cleared while the level is held and then released, which shows that the status follows the pad rather than a latch. Writes to the read-only offsets and a mask change isolate the masked view and the one-cycle interrupt delay from the raw status.

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPIN     = 32,
  parameter int AW       = 8,
  parameter int DRV_BITS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            addr,
  input  logic                     wr_en,
  input  logic [NPIN-1:0]          wr_data,
  output logic [NPIN-1:0]          rd_data,
  input  logic [NPIN-1:0]          pad_in,
  output logic [NPIN-1:0]          pad_out,
  output logic [NPIN-1:0]          pad_oe,
  output logic [NPIN-1:0]          pull_up,
  output logic [NPIN-1:0]          pull_dn,
  output logic [NPIN*DRV_BITS-1:0] drive_code,
  output logic                     irq
);
  localparam logic [AW-1:0] A_IN   = AW'('h00);
  localparam logic [AW-1:0] A_DOUT = AW'('h04);
  localparam logic [AW-1:0] A_OE   = AW'('h08);
  localparam logic [AW-1:0] A_LVL  = AW'('h0C);
  localparam logic [AW-1:0] A_DUAL = AW'('h10);
  localparam logic [AW-1:0] A_POL  = AW'('h14);
  localparam logic [AW-1:0] A_MASK = AW'('h18);
  localparam logic [AW-1:0] A_RAW  = AW'('h1C);
  localparam logic [AW-1:0] A_MSK  = AW'('h20);
  localparam logic [AW-1:0] A_CLR  = AW'('h24);
  localparam logic [AW-1:0] A_PSEL = AW'('h34);
  localparam logic [AW-1:0] A_PEN  = AW'('h38);
  localparam logic [AW-1:0] A_DRV  = AW'('h58);

  logic [NPIN-1:0] dout_q, oe_q, lvl_q, dual_q, pol_q, mask_q, raw_q, psel_q, pen_q;
  logic [DRV_BITS-1:0][NPIN-1:0] drv_q;
  logic [NPIN-1:0] s1_q, s2_q, prev_q;
  logic [NPIN-1:0] clr, rise, fall, edge_hit, lvl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0; oe_q <= '0; lvl_q <= '0; dual_q <= '0; pol_q <= '0;
      mask_q <= '0; psel_q <= '0; pen_q <= '0; drv_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DOUT: dout_q <= wr_data;
        A_OE:   oe_q   <= wr_data;
        A_LVL:  lvl_q  <= wr_data;
        A_DUAL: dual_q <= wr_data;
        A_POL:  pol_q  <= wr_data;
        A_MASK: mask_q <= wr_data;
        A_PSEL: psel_q <= wr_data;
        A_PEN:  pen_q  <= wr_data;
        default: ;
      endcase
      for (int i = 0; i < DRV_BITS; i++)
        if (addr == A_DRV + AW'(4 * i)) drv_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0; s2_q <= '0; prev_q <= '0;
    end else begin
      s1_q <= pad_in; s2_q <= s1_q; prev_q <= s2_q;
    end
  end

  assign clr      = (wr_en && addr == A_CLR) ? wr_data : '0;
  assign rise     = s2_q & ~prev_q;
  assign fall     = ~s2_q & prev_q;
  assign edge_hit = (dual_q & (rise | fall)) | (~dual_q & ((pol_q & rise) | (~pol_q & fall)));
  assign lvl_hit  = (pol_q & s2_q) | (~pol_q & ~s2_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      irq   <= 1'b0;
    end else begin
      raw_q <= (lvl_q & lvl_hit) | (~lvl_q & (edge_hit | (raw_q & ~clr)));
      irq   <= |(raw_q & mask_q);
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_IN:   rd_data = s2_q;
      A_DOUT: rd_data = dout_q;
      A_OE:   rd_data = oe_q;
      A_LVL:  rd_data = lvl_q;
      A_DUAL: rd_data = dual_q;
      A_POL:  rd_data = pol_q;
      A_MASK: rd_data = mask_q;
      A_RAW:  rd_data = raw_q;
      A_MSK:  rd_data = raw_q & mask_q;
      A_PSEL: rd_data = psel_q;
      A_PEN:  rd_data = pen_q;
      default: ;
    endcase
    for (int i = 0; i < DRV_BITS; i++)
      if (addr == A_DRV + AW'(4 * i)) rd_data = drv_q[i];
  end

  assign pad_out = dout_q & oe_q;
  assign pad_oe  = oe_q;
  assign pull_up = pen_q & psel_q;
  assign pull_dn = pen_q & ~psel_q;

  for (genvar n = 0; n < NPIN; n++) begin : g_pin
    for (genvar i = 0; i < DRV_BITS; i++) begin : g_bit
      assign drive_code[n*DRV_BITS+i] = drv_q[i][n];
    end
  end
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   addr,
  input logic            wr_en,
  input logic [NPIN-1:0] wr_data,
  input logic            irq,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] raw_q,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] lvl_q,
  input logic [NPIN-1:0] drv0_q
);
  logic [NPIN-1:0] clr_v;
  assign clr_v = (wr_en && addr == AW'('h24)) ? wr_data : '0;

  assert_irq_follows_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == (|$past(raw_q & mask_q))));

  assert_edge_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (($past(raw_q & ~lvl_q & ~clr_v) & ~raw_q) == '0));

  assert_disable_all_drivers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h08) && wr_data == '0) |=> (pad_out == '0));

  assert_drive_word0_written_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h58)) |=> (drv0_q == $past(wr_data)));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .irq(irq), .pad_out(pad_out), .raw_q(raw_q), .mask_q(mask_q),
  .lvl_q(lvl_q), .drv0_q(drv_q[0])
);

// File: tb/gpio_bank_irq_tb.sv
`timescale 1ns/1ps
module gpio_bank_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] pad_in = '0;
  logic [31:0] rd_data, pad_out, pad_oe, pull_up, pull_dn;
  logic [95:0] drive_code;
  logic        irq;

  int total = 0, bad = 0;
  bit run = 0;

  always #5 clk = ~clk;

  gpio_bank_irq u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .drive_code(drive_code), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_dout, m_oe, m_lvl, m_dual, m_pol, m_mask, m_raw, m_psel, m_pen;
  logic [31:0] m_drv [3];
  logic [31:0] hist [$];
  logic [31:0] nraw, clrv;
  logic        m_irq;
  bit cur, old, hit;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dout = 0; m_oe = 0; m_lvl = 0; m_dual = 0; m_pol = 0; m_mask = 0;
      m_raw = 0; m_psel = 0; m_pen = 0; m_irq = 0;
      for (int i = 0; i < 3; i++) m_drv[i] = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      clrv = (wr_en && addr == 8'h24) ? wr_data : 32'h0;
      for (int n = 0; n < 32; n++) begin
        cur = hist[1][n]; old = hist[0][n];
        if (m_lvl[n]) nraw[n] = (cur == m_pol[n]);
        else begin
          if (m_dual[n]) hit = (cur != old);
          else if (m_pol[n]) hit = cur && !old;
          else hit = !cur && old;
          nraw[n] = hit || (m_raw[n] && !clrv[n]);
        end
      end
      m_irq = (m_raw & m_mask) != 0;
      m_raw = nraw;
      hist.push_back(pad_in);
      void'(hist.pop_front());
      if (wr_en) begin
        case (addr)
          8'h04: m_dout = wr_data;
          8'h08: m_oe   = wr_data;
          8'h0C: m_lvl  = wr_data;
          8'h10: m_dual = wr_data;
          8'h14: m_pol  = wr_data;
          8'h18: m_mask = wr_data;
          8'h34: m_psel = wr_data;
          8'h38: m_pen  = wr_data;
          8'h58: m_drv[0] = wr_data;
          8'h5C: m_drv[1] = wr_data;
          8'h60: m_drv[2] = wr_data;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return hist[1];
      8'h04: return m_dout;
      8'h08: return m_oe;
      8'h0C: return m_lvl;
      8'h10: return m_dual;
      8'h14: return m_pol;
      8'h18: return m_mask;
      8'h1C: return m_raw;
      8'h20: return m_raw & m_mask;
      8'h34: return m_psel;
      8'h38: return m_pen;
      8'h58: return m_drv[0];
      8'h5C: return m_drv[1];
      8'h60: return m_drv[2];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(input logic [7:0] a);
    case (a)
      8'h00: return "R3";
      8'h1C: return "R4";
      8'h20: return "R7";
      8'h58, 8'h5C, 8'h60: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [95:0] m_code;
  always @(posedge clk) begin
    #3;
    if (run && rst_n) begin
      for (int n = 0; n < 32; n++)
        for (int i = 0; i < 3; i++) m_code[n*3+i] = m_drv[i][n];
      chk(rtag(addr), {64'h0, rd_data}, {64'h0, m_read(addr)});
      chk("R2", {32'h0, pad_oe, pad_out}, {32'h0, m_oe, m_dout & m_oe});
      chk("R9", {32'h0, pull_up, pull_dn}, {32'h0, m_pen & m_psel, m_pen & ~m_psel});
      chk("R10", drive_code, m_code);
      chk("R7", {95'h0, irq}, {95'h0, m_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    chk(tag, {64'h0, rd_data}, {64'h0, exp});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; run = 1;
    // R1 reset state
    #1;
    chk("R1", {64'h0, pad_oe}, 96'h0);
    chk("R1", {95'h0, irq}, 96'h0);
    chk("R1", drive_code, 96'h0);
    chk("R1", {32'h0, pull_up, pull_dn}, 96'h0);
    rdchk("R1", 8'h18, 32'h0);

    // R2 output gating
    wr(8'h04, 32'hA5A5_A5A5);
    wr(8'h08, 32'h0000_FFFF);
    #1 chk("R2", {64'h0, pad_out}, {64'h0, 32'h0000_A5A5});

    // R9 pulls
    wr(8'h38, 32'hF0F0_F0F0);
    wr(8'h34, 32'hFF00_FF00);
    #1 chk("R9", {32'h0, pull_up, pull_dn}, {32'h0, 32'hF000_F000, 32'h00F0_00F0});

    // R10 drive codes: pin0 = 7 (16 mA), pin5 = 2 (6 mA)
    wr(8'h58, 32'h0000_0001);
    wr(8'h5C, 32'h0000_0021);
    wr(8'h60, 32'h0000_0001);
    #1 chk("R10", {93'h0, drive_code[2:0]}, 96'd7);
    chk("R10", {93'h0, drive_code[17:15]}, 96'd2);

    // R3 synchronizer latency
    @(negedge clk); addr = 8'h00; pad_in = 32'h1234_5678;
    @(posedge clk); #2 chk("R3", {64'h0, rd_data}, 96'h0);
    @(posedge clk); #2 chk("R3", {64'h0, rd_data}, {64'h0, 32'h1234_5678});
    @(negedge clk); pad_in = 32'h0;
    settle();
    wr(8'h24, 32'hFFFF_FFFF);

    // configure: pin1 rising, pin2 falling, pin3 dual (pol 0), pin4 level high
    wr(8'h14, 32'h0000_0012);
    wr(8'h10, 32'h0000_0008);
    wr(8'h0C, 32'h0000_0010);
    wr(8'h18, 32'h0000_001E);
    rdchk("R4", 8'h1C, 32'h0);

    // R4 edge polarity
    @(negedge clk); pad_in = 32'h2; settle();
    rdchk("R4", 8'h1C, 32'h2);
    @(negedge clk); #1 chk("R7", {95'h0, irq}, 96'h1);
    @(negedge clk); pad_in = 32'h0; settle();
    rdchk("R4", 8'h1C, 32'h2);
    @(negedge clk); pad_in = 32'h4; settle();
    rdchk("R4", 8'h1C, 32'h2);
    @(negedge clk); pad_in = 32'h0; settle();
    rdchk("R4", 8'h1C, 32'h6);

    // R5 dual edge catches a rising edge despite polarity 0
    @(negedge clk); pad_in = 32'h8; settle();
    rdchk("R5", 8'h1C, 32'hE);
    wr(8'h24, 32'h8);
    @(negedge clk); pad_in = 32'h0; settle();
    rdchk("R5", 8'h1C, 32'hE);
    wr(8'h24, 32'h8);

    // R6 level mode follows the pad, clear cannot hold it
    @(negedge clk); pad_in = 32'h10; settle();
    rdchk("R6", 8'h1C, 32'h16);
    wr(8'h24, 32'h10);
    rdchk("R6", 8'h1C, 32'h16);
    @(negedge clk); pad_in = 32'h0; settle();
    rdchk("R6", 8'h1C, 32'h06);

    // R8 clear coinciding with a new rising edge on pin1
    @(negedge clk); pad_in = 32'h2;
    @(negedge clk);
    wr(8'h24, 32'h2);
    rdchk("R8", 8'h1C, 32'h06);
    wr(8'h24, 32'h0);
    rdchk("R8", 8'h1C, 32'h06);
    wr(8'h24, 32'h2);
    rdchk("R8", 8'h1C, 32'h04);

    // R7 masked view and registered irq
    rdchk("R7", 8'h20, 32'h04);
    wr(8'h18, 32'h10);
    rdchk("R7", 8'h20, 32'h0);
    @(negedge clk); #1 chk("R7", {95'h0, irq}, 96'h0);

    // R11 read-only and unmapped offsets
    wr(8'h1C, 32'hFFFF_FFFF);
    rdchk("R11", 8'h1C, 32'h04);
    wr(8'h00, 32'hFFFF_FFFF);
    rdchk("R11", 8'h00, 32'h2);
    rdchk("R11", 8'h24, 32'h0);
    rdchk("R11", 8'h40, 32'h0);
    rdchk("R11", 8'h08, 32'h0000_FFFF);

    // R2 turning all drivers off
    wr(8'h08, 32'h0);
    #1 chk("R2", {64'h0, pad_out}, 96'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule